// File: doc/BRIEF.md
# Video filter/pass-through mode controller

This controller decides whether a video separation pipeline runs in filtering mode or hands its inputs straight through to the outputs. The decision comes from two pins. One is a bypass request, which may carry a fast carrier-rate waveform. The other is a select pin that sets the request's polarity and also the timing rule for returning to filtering. The pipeline's analog parts are modelled only by the control signals that leave this block, and by one input: the per-field vertical pulse from the sync separator.

The request pin first passes through a hold filter. The filter's level changes only after the raw pin has kept a new value for `HOLD` consecutive clocks. The conditioned level is combined with the select pin to give the wanted mode. Leaving filtering mode takes effect at once. Entering filtering mode takes effect on the next clock when the select pin is low. When the select pin is high, entry waits for the next rising edge of the vertical pulse. One stop signal steers all of the output selectors. A clock-run enable releases the clock processing, and a status output reports the mode in force.

Top module: `vmode_ctrl`

## Requirements
- R1: The wanted mode uses the conditioned request level `q` and `sync_sel_i` `s`. Filtering is wanted for q=0,s=0 and for q=1,s=1. Pass-through is wanted for q=1,s=0 and for q=0,s=1.
- R2: When pass-through becomes wanted, `stop_o` is 1 in that same cycle. It waits for no vertical pulse.
- R3: With `sync_sel_i` low, filtering takes effect (`stop_o`=0, `mode_on_o`=1) on the clock edge after the one on which it became wanted.
- R4: With `sync_sel_i` high, entry into filtering waits for a rising edge of `vpulse_i` (a 0 sampled at one edge, then a 1 at the next). It takes effect on the edge that samples the 1. A pulse that is already high when entry becomes pending does not count.
- R5: A pending synchronous entry is cancelled if pass-through is wanted again before the pulse. A pulse that arrives while pass-through is wanted leaves the block in pass-through.
- R6: `clk_run_o` is 0 whenever pass-through is wanted, whatever `vpulse_i` does. It is 1 whenever filtering is wanted, including while entry is pending.
- R7: `mode_on_o` is 1 only while filtering is in force, and it equals the inverse of `stop_o` (1 = pass-through inputs routed to the outputs).
- R8: The conditioned level follows `byp_req_i` only after the pin has held a new value at `HOLD` consecutive clock edges. Shorter pulses, and toggling faster than that, have no effect on the outputs.
- R9: While reset is asserted, `stop_o`=1, `mode_on_o`=0 and `clk_run_o`=0, and the conditioned level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byp_req_i | input | 1 | Raw bypass request pin |
| sync_sel_i | input | 1 | Selects request polarity and synchronous filter entry |
| vpulse_i | input | 1 | Per-field vertical pulse |
| stop_o | output | 1 | 1 selects the pass-through inputs on all output selectors |
| clk_run_o | output | 1 | Releases PLL and clock processing |
| mode_on_o | output | 1 | 1 while filtering mode is active |

## Verification
The bench builds the block with `HOLD`=4. This is short enough that the exact edge on which the conditioned level flips can be reached and checked. It also lets a pulse one clock shorter than the hold, and a toggle at every clock, be shown to leave the mode unchanged. With this short hold, every request change settles in a few cycles. That leaves room to arm a synchronous entry, withdraw it before the vertical pulse, and re-arm it against a pulse that was already high.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

  typedef enum logic [1:0] {
    VM_PASS  = 2'd0,
    VM_ARMED = 2'd1,
    VM_FILT  = 2'd2
  } vm_state_e;

  // Equal levels of request and select want filtering; differing levels want pass-through.
  function automatic logic pass_wanted(input logic req_lvl, input logic sel);
    return req_lvl ^ sel;
  endfunction

  // Next state of the mode sequencer.
  function automatic vm_state_e next_mode(input vm_state_e cur, input logic want_pass,
                                          input logic sel, input logic vedge);
    vm_state_e nxt;
    if (want_pass)                  nxt = VM_PASS;
    else if (cur == VM_FILT)        nxt = VM_FILT;
    else if (!sel || vedge)         nxt = VM_FILT;
    else                            nxt = VM_ARMED;
    return nxt;
  endfunction

endpackage

// File: rtl/vm_req_filter.sv
module vm_req_filter #(
  parameter int HOLD = 8,
  localparam int CW  = (HOLD < 2) ? 1 : $clog2(HOLD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_i,
  output logic          lvl_o,
  output logic [CW-1:0] cnt_o
);

  logic lvl_q;

  generate
    if (HOLD < 2) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= raw_i;
      end
      assign cnt_o = '0;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      logic          differ;
      logic          expire;

      assign differ = (raw_i != lvl_q);
      assign expire = (cnt_q == CW'(HOLD - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl_q <= 1'b0;
          cnt_q <= '0;
        end else if (!differ) begin
          cnt_q <= '0;
        end else if (expire) begin
          lvl_q <= raw_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign cnt_o = cnt_q;
    end
  endgenerate

  assign lvl_o = lvl_q;

endmodule

// File: rtl/vm_edge.sv
module vm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pulse_i;
  end

  assign rise_o = pulse_i & ~prev_q;

endmodule

// File: rtl/vm_seq.sv
module vm_seq
  import vmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      want_pass_i,
  input  logic      sel_i,
  input  logic      vedge_i,
  output vm_state_e state_o,
  output logic      run_ok_o
);

  vm_state_e state_q;
  logic      run_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= VM_PASS;
      run_ok_q <= 1'b0;
    end else begin
      state_q  <= next_mode(state_q, want_pass_i, sel_i, vedge_i);
      run_ok_q <= 1'b1;
    end
  end

  assign state_o  = state_q;
  assign run_ok_o = run_ok_q;

endmodule

// File: rtl/vmode_ctrl.sv
module vmode_ctrl
  import vmode_pkg::*;
#(
  parameter int HOLD = 8,
  localparam int CW  = (HOLD < 2) ? 1 : $clog2(HOLD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byp_req_i,
  input  logic sync_sel_i,
  input  logic vpulse_i,
  output logic stop_o,
  output logic clk_run_o,
  output logic mode_on_o
);

  logic          req_lvl;
  logic [CW-1:0] hold_cnt;
  logic          want_pass;
  logic          vedge;
  logic          run_ok;
  logic          armed;
  vm_state_e     state;

  vm_req_filter #(.HOLD(HOLD)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (byp_req_i),
    .lvl_o (req_lvl),
    .cnt_o (hold_cnt)
  );

  vm_edge u_vedge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (vpulse_i),
    .rise_o  (vedge)
  );

  assign want_pass = pass_wanted(req_lvl, sync_sel_i);

  vm_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .want_pass_i (want_pass),
    .sel_i       (sync_sel_i),
    .vedge_i     (vedge),
    .state_o     (state),
    .run_ok_o    (run_ok)
  );

  assign armed     = (state == VM_ARMED);
  // Leaving filtering bypasses the sequencer register so it acts in the same cycle.
  assign stop_o    = (state != VM_FILT) | want_pass;
  assign mode_on_o = ~stop_o;
  assign clk_run_o = run_ok & ~want_pass;

endmodule

// File: rtl/vmode_ctrl_chk.sv
module vmode_ctrl_chk #(
  parameter int HOLD = 8,
  localparam int CW  = (HOLD < 2) ? 1 : $clog2(HOLD)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byp_req_i,
  input logic          sync_sel_i,
  input logic          stop_o,
  input logic          clk_run_o,
  input logic          mode_on_o,
  input logic          req_lvl,
  input logic [CW-1:0] hold_cnt,
  input logic          want_pass,
  input logic          vedge,
  input logic          armed
);

  p_pass_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    want_pass |-> stop_o);

  p_async_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!want_pass && !sync_sel_i) |=> (mode_on_o || want_pass));

  p_sync_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_on_o && sync_sel_i && !vedge) |=> !mode_on_o);

  p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && want_pass) |=> (!armed && !mode_on_o));

  p_clk_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    want_pass |-> !clk_run_o);

  p_status_filter_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_on_o |-> (!want_pass && !stop_o));

  p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(req_lvl) |-> (req_lvl == $past(byp_req_i)));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(hold_cnt) < ((HOLD < 2) ? 1 : HOLD)));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r9: assert (stop_o && !mode_on_o && !clk_run_o && !req_lvl);
    end
  end

endmodule

bind vmode_ctrl vmode_ctrl_chk #(.HOLD(HOLD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byp_req_i  (byp_req_i),
  .sync_sel_i (sync_sel_i),
  .stop_o     (stop_o),
  .clk_run_o  (clk_run_o),
  .mode_on_o  (mode_on_o),
  .req_lvl    (req_lvl),
  .hold_cnt   (hold_cnt),
  .want_pass  (want_pass),
  .vedge      (vedge),
  .armed      (armed)
);

// File: tb/vmode_ctrl_tb_top.sv
module vmode_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int HOLD  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byp_req = 1'b0;
  logic sync_sel = 1'b0;
  logic vpulse = 1'b0;
  logic stop, clk_run, mode_on;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  vmode_ctrl #(.HOLD(HOLD)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .byp_req_i  (byp_req),
    .sync_sel_i (sync_sel),
    .vpulse_i   (vpulse),
    .stop_o     (stop),
    .clk_run_o  (clk_run),
    .mode_on_o  (mode_on)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Expected outputs from a mode: filtering -> stop 0, status 1.
  task automatic expect_mode(input string req, input logic filt, input logic run);
    check(req, "stop_o", stop, ~filt);
    check(req, "mode_on_o", mode_on, filt);
    check(req, "clk_run_o", clk_run, run);
  endtask

  task automatic t_reset;
    step(2);
    expect_mode("R9", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(1);
    expect_mode("R1", 1'b1, 1'b1);   // q=0,s=0 filtering, entered right after reset (R3)
  endtask

  task automatic t_async;
    byp_req = 1'b1;
    step(HOLD - 1);
    expect_mode("R8", 1'b1, 1'b1);   // not yet held long enough
    step(1);
    expect_mode("R2", 1'b0, 1'b0);   // q=1,s=0 pass-through, immediate (R1)
    byp_req = 1'b0;
    step(HOLD);
    check("R6", "clk_run_o", clk_run, 1'b1);
    check("R3", "stop_o", stop, 1'b1);
    step(1);
    expect_mode("R3", 1'b1, 1'b1);
  endtask

  task automatic t_glitch;
    byp_req = 1'b1;
    step(HOLD - 1);
    byp_req = 1'b0;
    step(1);
    for (int i = 0; i < 2*HOLD; i++) begin
      check("R8", "stop_o short pulse", stop, 1'b0);
      step(1);
    end
    for (int i = 0; i < 20; i++) begin
      byp_req = ~byp_req;
      step(1);
      check("R8", "stop_o toggling", stop, 1'b0);
    end
    byp_req = 1'b0;
    step(HOLD + 1);
    expect_mode("R8", 1'b1, 1'b1);
  endtask

  task automatic t_sync;
    sync_sel = 1'b1;
    #1;
    expect_mode("R1", 1'b0, 1'b0);   // q=0,s=1 pass-through at once
    byp_req = 1'b1;
    step(HOLD + 1);
    check("R6", "clk_run_o pending", clk_run, 1'b1);
    step(5);
    expect_mode("R4", 1'b0, 1'b1);   // still waiting for the field pulse
    vpulse = 1'b1;
    step(1);
    expect_mode("R4", 1'b1, 1'b1);   // q=1,s=1 filtering (R1)
    vpulse = 1'b0;
    step(1);
    expect_mode("R7", 1'b1, 1'b1);
  endtask

  task automatic t_cancel;
    byp_req = 1'b0;
    step(HOLD);
    expect_mode("R2", 1'b0, 1'b0);
    byp_req = 1'b1;
    step(HOLD + 1);
    expect_mode("R4", 1'b0, 1'b1);   // armed
    byp_req = 1'b0;
    step(HOLD + 1);
    vpulse = 1'b1;
    step(1);
    vpulse = 1'b0;
    expect_mode("R5", 1'b0, 1'b0);   // pulse during pass-through ignored (R6)
    step(2);
    expect_mode("R5", 1'b0, 1'b0);
    // Pulse held high before arming must not count as an edge.
    vpulse = 1'b1;
    step(2);
    byp_req = 1'b1;
    step(HOLD + 4);
    expect_mode("R4", 1'b0, 1'b1);
    vpulse = 1'b0;
    step(1);
    expect_mode("R4", 1'b0, 1'b1);
    vpulse = 1'b1;
    step(1);
    expect_mode("R4", 1'b1, 1'b1);
    vpulse = 1'b0;
    step(1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_async();
    t_glitch();
    t_sync();
    t_cancel();
    finish_run();
  end

endmodule